// File: doc/BRIEF.md
# Bit-Serial Arithmetic Unit

This block is the arithmetic core of a small control computer. All of its arithmetic runs through a single one-bit adder/subtractor with a carry flip-flop, one bit per clock. It holds three W-bit shift registers: an accumulator, an operand register and an auxiliary register. The unit does no instruction decoding. An external controller picks the operation with a 3-bit code and pulses a start strobe. The unit then runs a fixed sequence of word times, each W clocks long.

The sequence has three stages. First, a load word time shifts both operands in from the scratch-pad register file, least significant bit first. Next come one or more execution word times. Last, an unload word time shifts the accumulator and auxiliary contents back out, least significant bit first. The unit exposes its current bit time and stage so that the register file can present and capture bits in step. A one-clock done pulse closes each operation.

Add, subtract and the two single-bit shifts take one execution word time. Multiply is unsigned shift-and-add over W word times. Divide is unsigned restoring division over 2W word times: each quotient bit needs a compare word and then an apply word.

Top module: `serial_arith_unit`

## Requirements
- R1: While reset is held and directly after it, busy_o, done_o, ld_o, unl_o, err_o, res_a_so and res_x_so are all 0, and bit_o is 0.
- R2: A start_i sampled high while idle accepts op_i, with codes 0 add, 1 subtract, 2 multiply, 3 divide, 4 shift left, 5 shift right. For the next W cycles, ld_o is 1 and bit_o counts 0 to W-1. Operand A (opa_si) and operand B (opb_si) are sampled one bit per cycle, least significant bit first.
- R3: Code 0 uses one execution word time. The unloaded res_a_so word is (A+B) mod 2^W, and res_x_so carries all zeros.
- R4: Code 1 uses one execution word time. The unloaded res_a_so word is (A-B) mod 2^W in two's complement, and res_x_so carries all zeros.
- R5: Code 2 uses W execution word times. res_a_so carries the upper W bits of the unsigned 2W-bit product A*B, and res_x_so carries the lower W bits.
- R6: Code 3 uses 2W execution word times. For B not zero, res_x_so carries the unsigned quotient A/B and res_a_so carries the remainder A mod B.
- R7: For code 3 with B = 0, err_o rises in the done cycle and stays high until the next accepted start. The quotient read out is all ones and the remainder read out equals A. err_o stays 0 for every other operation.
- R8: Code 4 gives (A<<1) mod 2^W and code 5 gives A>>1 on res_a_so. Each uses one execution word time, fills the vacated bit with 0, and puts all zeros on res_x_so.
- R9: The unload stage follows the last execution word time directly. For W cycles, unl_o is 1 and bit_o counts 0 to W-1. Result bit bit_o is on res_a_so and res_x_so during each of those cycles.
- R10: done_o is 1 for exactly the one cycle after the last unload cycle, and the unit is idle in the next cycle. busy_o is 1 from the cycle after acceptance through the done cycle.
- R11: A start_i that arrives while busy_o is 1, including in the done cycle, is ignored. It has no effect on the running operation, its result or the return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 3 | Operation code |
| opa_si | input | 1 | Serial operand A, LSB first, during load |
| opb_si | input | 1 | Serial operand B, LSB first, during load |
| busy_o | output | 1 | Operation in progress |
| ld_o | output | 1 | Load word time active |
| unl_o | output | 1 | Unload word time active |
| bit_o | output | $clog2(W) | Bit time within the current word time |
| res_a_so | output | 1 | Serial accumulator result (sum, high product word, remainder) |
| res_x_so | output | 1 | Serial auxiliary result (low product word, quotient) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide-by-zero flag |

## Verification
Let the start edge be cycle 0 and let E be the execution word count times W. Operand bit k is captured at clock edge k+1. Result bit j appears in cycle W+E+j, and done follows in cycle 2W+E. E is W for add, subtract and the shifts, W*W for multiply and 2W*W for divide.

The bench keeps its own cycle index from the edge at which it saw the start accepted. It derives every expected stage flag, bit time and result bit from that index alone. It compares all outputs at the falling edge of every cycle, so each result is checked in exactly the cycle it is due. Stray starts are placed inside an execution word and in the done cycle.

// File: rtl/sau_pkg.sv
package sau_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_MUL = 3'd2,
      OP_DIV = 3'd3,
      OP_SHL = 3'd4,
      OP_SHR = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_EXEC,
      PH_UNLD,
      PH_DONE
   } phase_e;
endpackage

// File: rtl/sau_bit_alu.sv
// One-bit full adder with a carry flip-flop; the carry is re-seeded on
// the first bit of every word time.
module sau_bit_alu (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic first,
   input  logic init,
   input  logic a,
   input  logic b,
   output logic sum,
   output logic cout
);
   logic c_q;
   logic cin;

   assign cin  = first ? init : c_q;
   assign sum  = a ^ b ^ cin;
   assign cout = (a & b) | (a & cin) | (b & cin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  c_q <= 1'b0;
      else if (en) c_q <= cout;
   end
endmodule

// File: rtl/sau_sequencer.sv
module sau_sequencer
   import sau_pkg::*;
#(
   parameter int W   = 16,
   parameter int CW  = $clog2(W),
   parameter int WCW = $clog2(2 * W) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  op_e           op_i,
   output op_e           op_o,
   output phase_e        ph_o,
   output logic [CW-1:0] bit_o,
   output logic          accept_o,
   output logic          first_o,
   output logic          last_bit_o,
   output logic          last_wrd_o,
   output logic          odd_wrd_o
);
   phase_e           ph_q;
   op_e              op_q;
   logic [CW-1:0]    bit_q;
   logic [WCW-1:0]   wrd_q;
   logic [WCW-1:0]   nw_m1;
   logic             last_bit;
   logic             last_wrd;

   always_comb begin
      unique case (op_q)
         OP_MUL:  nw_m1 = WCW'(W - 1);
         OP_DIV:  nw_m1 = WCW'(2 * W - 1);
         default: nw_m1 = '0;
      endcase
   end

   assign last_bit = (bit_q == CW'(W - 1));
   assign last_wrd = (wrd_q == nw_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         op_q  <= OP_ADD;
         bit_q <= '0;
         wrd_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start_i) begin
               ph_q  <= PH_LOAD;
               op_q  <= op_i;
               bit_q <= '0;
               wrd_q <= '0;
            end
            PH_LOAD: begin
               bit_q <= last_bit ? '0 : bit_q + 1'b1;
               if (last_bit) ph_q <= PH_EXEC;
            end
            PH_EXEC: begin
               bit_q <= last_bit ? '0 : bit_q + 1'b1;
               if (last_bit) begin
                  wrd_q <= last_wrd ? '0 : wrd_q + 1'b1;
                  if (last_wrd) ph_q <= PH_UNLD;
               end
            end
            PH_UNLD: begin
               bit_q <= last_bit ? '0 : bit_q + 1'b1;
               if (last_bit) ph_q <= PH_DONE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign op_o       = op_q;
   assign ph_o       = ph_q;
   assign bit_o      = bit_q;
   assign accept_o   = (ph_q == PH_IDLE) && start_i;
   assign first_o    = (bit_q == '0);
   assign last_bit_o = last_bit;
   assign last_wrd_o = last_wrd;
   assign odd_wrd_o  = wrd_q[0];

   // R11: a start seen while busy leaves the latched operation untouched
   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE && start_i) |=> $stable(op_q));

   // R10: the completion state lasts one cycle and returns to idle
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DONE) |=> (ph_q == PH_IDLE));

   // R9: unloading starts only right after the final execution bit
   p_unld_after_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_UNLD && bit_q == '0) |-> $past(ph_q == PH_EXEC));
endmodule

// File: rtl/sau_datapath.sv
module sau_datapath
   import sau_pkg::*;
#(
   parameter int W = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph,
   input  op_e    op,
   input  logic   accept,
   input  logic   first,
   input  logic   last_bit,
   input  logic   last_wrd,
   input  logic   odd_wrd,
   input  logic   ser_a,
   input  logic   ser_b,
   output logic   res_a,
   output logic   res_x,
   output logic   err
);
   logic [W-1:0] acc_q, opr_q, aux_q;
   logic         q_q;      // pending quotient bit from the compare pass
   logic         msb_q;    // bit shifted out of the partial remainder
   logic         nz_q;     // divisor had a set bit
   logic         err_q;
   logic         alu_a, alu_b, alu_init, sum, cout, div_bit;

   always_comb begin
      alu_a    = acc_q[0];
      alu_b    = opr_q[0];
      alu_init = 1'b0;
      unique case (op)
         OP_SUB, OP_DIV: begin
            alu_b    = ~opr_q[0];
            alu_init = 1'b1;
         end
         OP_MUL: alu_b = opr_q[0] & aux_q[0];
         // both adder inputs equal: sum replays the stored carry (previous
         // bit), cout stores the current bit, giving a one-bit delay
         OP_SHL: alu_b = acc_q[0];
         default: ;
      endcase
   end

   sau_bit_alu u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ph == PH_EXEC),
      .first (first),
      .init  (alu_init),
      .a     (alu_a),
      .b     (alu_b),
      .sum   (sum),
      .cout  (cout)
   );

   assign div_bit = q_q ? sum : acc_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0; opr_q <= '0; aux_q <= '0;
         q_q <= 1'b0; msb_q <= 1'b0; nz_q <= 1'b0; err_q <= 1'b0;
      end else if (accept) begin
         acc_q <= '0; opr_q <= '0; aux_q <= '0;
         q_q <= 1'b0; msb_q <= 1'b0; nz_q <= 1'b0; err_q <= 1'b0;
      end else begin
         unique case (ph)
            PH_LOAD: begin
               opr_q <= {ser_b, opr_q[W-1:1]};
               nz_q  <= nz_q | ser_b;
               if (op == OP_MUL) begin
                  aux_q <= {ser_a, aux_q[W-1:1]};
               end else if (op == OP_DIV) begin
                  if (last_bit) begin
                     // first left shift of the dividend into the remainder
                     acc_q <= {{(W-1){1'b0}}, ser_a};
                     aux_q <= {aux_q[W-1:1], 1'b0};
                  end else begin
                     aux_q <= {ser_a, aux_q[W-1:1]};
                  end
               end else begin
                  acc_q <= {ser_a, acc_q[W-1:1]};
               end
            end
            PH_EXEC: begin
               opr_q <= {opr_q[0], opr_q[W-1:1]};
               unique case (op)
                  OP_SHR: acc_q <= {(last_bit ? 1'b0 : acc_q[1]), acc_q[W-1:1]};
                  OP_MUL: begin
                     if (last_bit) begin
                        acc_q <= {cout, sum, acc_q[W-1:2]};
                        aux_q <= {acc_q[1], aux_q[W-1:1]};
                     end else begin
                        acc_q <= {sum, acc_q[W-1:1]};
                     end
                  end
                  OP_DIV: begin
                     if (!odd_wrd) begin
                        // compare pass: remainder only rotates
                        acc_q <= {acc_q[0], acc_q[W-1:1]};
                        if (last_bit) q_q <= msb_q | cout;
                     end else if (!last_bit) begin
                        acc_q <= {div_bit, acc_q[W-1:1]};
                     end else begin
                        aux_q <= {aux_q[W-2:0], q_q};
                        if (last_wrd) begin
                           acc_q <= {div_bit, acc_q[W-1:1]};
                        end else begin
                           acc_q <= {acc_q[W-1:1], aux_q[W-1]};
                           msb_q <= div_bit;
                        end
                     end
                  end
                  default: acc_q <= {sum, acc_q[W-1:1]};
               endcase
            end
            PH_UNLD: begin
               acc_q <= {acc_q[0], acc_q[W-1:1]};
               aux_q <= {aux_q[0], aux_q[W-1:1]};
               if (last_bit && op == OP_DIV && !nz_q) err_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign res_a = acc_q[0];
   assign res_x = aux_q[0];
   assign err   = err_q;

   // R3: single-word operations never disturb the auxiliary register
   p_aux_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_EXEC && op != OP_MUL && op != OP_DIV) |-> (aux_q == '0));

   // R7: the error flag only rises on a divide, entering completion
   p_err_div_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (op == OP_DIV && ph == PH_DONE));
endmodule

// File: rtl/serial_arith_unit.sv
module serial_arith_unit
   import sau_pkg::*;
#(
   parameter int W  = 16,
   parameter int CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    op_i,
   input  logic          opa_si,
   input  logic          opb_si,
   output logic          busy_o,
   output logic          ld_o,
   output logic          unl_o,
   output logic [CW-1:0] bit_o,
   output logic          res_a_so,
   output logic          res_x_so,
   output logic          done_o,
   output logic          err_o
);
   localparam int WCW = $clog2(2 * W) + 1;

   generate
      if (W < 4) begin : g_bad_width
         $error("serial_arith_unit: W must be at least 4");
      end
      if (CW != $clog2(W)) begin : g_bad_cw
         $error("serial_arith_unit: CW must equal clog2(W)");
      end
   endgenerate

   op_e    op;
   phase_e ph;
   logic   accept, first, last_bit, last_wrd, odd_wrd;

   sau_sequencer #(.W(W), .CW(CW), .WCW(WCW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_e'(op_i)),
      .op_o       (op),
      .ph_o       (ph),
      .bit_o      (bit_o),
      .accept_o   (accept),
      .first_o    (first),
      .last_bit_o (last_bit),
      .last_wrd_o (last_wrd),
      .odd_wrd_o  (odd_wrd)
   );

   sau_datapath #(.W(W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .op       (op),
      .accept   (accept),
      .first    (first),
      .last_bit (last_bit),
      .last_wrd (last_wrd),
      .odd_wrd  (odd_wrd),
      .ser_a    (opa_si),
      .ser_b    (opb_si),
      .res_a    (res_a_so),
      .res_x    (res_x_so),
      .err      (err_o)
   );

   assign busy_o = (ph != PH_IDLE);
   assign ld_o   = (ph == PH_LOAD);
   assign unl_o  = (ph == PH_UNLD);
   assign done_o = (ph == PH_DONE);
endmodule

// File: tb/serial_arith_unit_tb_top.sv
module serial_arith_unit_tb_top;
   localparam int W    = 16;
   localparam int CW   = $clog2(W);
   localparam int MASK = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_r = 1'b0;
   logic [2:0]    op_r = 3'd0;
   logic          opa = 1'b0, opb = 1'b0;
   logic          busy_o, ld_o, unl_o, res_a_so, res_x_so, done_o, err_o;
   logic [CW-1:0] bit_o;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int t_a = 0, t_b = 0;
   int m_k = -1, m_op = 0, m_a = 0, m_b = 0, m_ra = 0, m_rx = 0, m_tot = 0, m_e = 0;
   logic m_err = 1'b0;
   logic finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   serial_arith_unit #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_r), .op_i(op_r),
      .opa_si(opa), .opb_si(opb), .busy_o(busy_o), .ld_o(ld_o),
      .unl_o(unl_o), .bit_o(bit_o), .res_a_so(res_a_so),
      .res_x_so(res_x_so), .done_o(done_o), .err_o(err_o)
   );

   task automatic check1(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s cyc=%0d act=%0h exp=%0h", req, cyc, act, exp);
      end
   endtask

   function automatic string res_tag(input int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R8";
      endcase
   endfunction

   // behavioural reference: cycle index since acceptance, results by integer math
   always @(posedge clk) begin
      longint p;
      cyc++;
      if (!rst_n) begin
         m_k = -1; m_err = 1'b0;
      end else if (m_k < 0) begin
         if (start_r) begin
            m_k = 0; m_op = int'(op_r); m_a = t_a & MASK; m_b = t_b & MASK;
            m_err = 1'b0; m_rx = 0;
            case (m_op)
               0: m_ra = (m_a + m_b) & MASK;
               1: m_ra = (m_a - m_b) & MASK;
               2: begin
                  p = longint'(m_a) * longint'(m_b);
                  m_ra = int'(p >> W); m_rx = int'(p) & MASK;
               end
               3: begin
                  if (m_b == 0) begin m_ra = m_a; m_rx = MASK; end
                  else begin m_ra = m_a % m_b; m_rx = m_a / m_b; end
               end
               4: m_ra = (m_a << 1) & MASK;
               default: m_ra = m_a >> 1;
            endcase
            m_e   = (m_op == 2) ? W * W : (m_op == 3) ? 2 * W * W : W;
            m_tot = 2 * W + m_e;
         end
      end else if (m_k == m_tot) begin
         m_k = -1;
      end else begin
         m_k++;
         if (m_k == m_tot && m_op == 3 && m_b == 0) m_err = 1'b1;
      end
      if (cyc > 20000 && !finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog cyc=%0d act=hung exp=finished", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // compare every output each cycle, then drive serial operand bits
   always @(negedge clk) begin
      int j;
      if (rst_n) begin
         check1("R10 busy", busy_o, (m_k >= 0));
         check1("R2 ld", ld_o, (m_k >= 0 && m_k < W));
         check1("R9 unl", unl_o, (m_k >= W + m_e && m_k < m_tot && m_k >= 0));
         check1("R10 done", done_o, (m_k >= 0 && m_k == m_tot));
         check1("R7 err", err_o, m_err);
         check1("R2 bit", bit_o, (m_k >= 0 && m_k < m_tot) ? (m_k % W) : 0);
         if (m_k >= W + m_e && m_k < m_tot) begin
            j = m_k - W - m_e;
            check1(res_tag(m_op), res_a_so, (m_ra >> j) & 1);
            check1(res_tag(m_op), res_x_so, (m_rx >> j) & 1);
         end
      end
      if (m_k >= 0 && m_k < W) begin
         opa = 1'((m_a >> m_k) & 1);
         opb = 1'((m_b >> m_k) & 1);
      end else begin
         opa = 1'b0; opb = 1'b0;
      end
   end

   task automatic run_op(input int op, input int a, input int b);
      @(negedge clk);
      op_r = 3'(op); t_a = a; t_b = b; start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
      while (m_k >= 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check1("R1 busy", busy_o, 0);
      check1("R1 done", done_o, 0);
      check1("R1 ld", ld_o, 0);
      check1("R1 unl", unl_o, 0);
      check1("R1 err", err_o, 0);
      check1("R1 res_a", res_a_so, 0);
      check1("R1 res_x", res_x_so, 0);
      check1("R1 bit", bit_o, 0);
      rst_n = 1'b1;

      run_op(0, 16'h1234, 16'h0FFF);   // R3
      run_op(0, 16'hFFFF, 16'h0001);   // R3 wrap
      run_op(1, 5, 7);                 // R4 negative
      run_op(1, 16'hA5A5, 16'hA5A5);   // R4 equal
      run_op(2, 16'hFFFF, 16'hFFFF);   // R5 largest
      run_op(2, 300, 200);             // R5
      run_op(2, 0, 16'h8001);          // R5 zero
      run_op(3, 1000, 7);              // R6
      run_op(3, 16'hFFFF, 1);          // R6
      run_op(3, 5, 9);                 // R6 divisor above dividend
      run_op(3, 16'hFFFF, 16'hFFFF);   // R6
      run_op(3, 16'h8000, 16'hC000);   // R6 top bit set
      run_op(3, 16'h1357, 0);          // R7 divide by zero
      check1("R7 held", err_o, 1);
      run_op(4, 16'h8001, 0);          // R8 shl
      check1("R7 cleared", err_o, 0);
      run_op(5, 16'h8001, 0);          // R8 shr
      run_op(4, 16'h7FFF, 0);          // R8

      // R11: stray starts during execution and in the done cycle
      @(negedge clk);
      op_r = 3'd3; t_a = 50000; t_b = 123; start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
      while (m_k != 20) @(negedge clk);
      op_r = 3'd0; t_a = 1; t_b = 1; start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
      while (m_k != m_tot) @(negedge clk);
      start_r = 1'b1;
      @(negedge clk);
      start_r = 1'b0;
      check1("R11 idle after done", busy_o, 0);
      repeat (3) @(negedge clk);
      check1("R11 still idle", busy_o, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule